// File: doc/BRIEF.md
# Block Lock and Write-Protect Manager

This block guards a byte-wide flash-style array of 32 erase blocks against unwanted programming and erasure. It listens to the same synchronous command bus that carries write and erase requests, decodes the two-cycle protection sequences, and keeps one stored lock bit per block. A write or erase request only reaches the array port when the target block is effectively unlocked. Requests that are refused, and malformed sequences, are reported through two sticky error flags.

Two kinds of state are kept apart. The stored lock bits live in a register file that is cleared only by the power-on reset. The effective protection is what the write and erase paths see. After either reset, every block is effectively locked until a protect-set sequence puts the stored bits into force. A master protect-reset latch opens every block regardless of its bit. Erasing a block clears its stored bit. The erase-all sequence always selects blocks by their true stored bits, even straight after reset.

A block query port returns, in the same cycle, whether a given block may be modified. Accepted requests come out one cycle after the confirming bus cycle as single-cycle pulses. Each pulse comes with the captured address, the data and a per-block erase-select vector.

Top module: `blk_lock_mgr`

## Requirements
- R1: The block index of any address is taken from address bits 18:14 (16K-byte blocks). The query output `qry_allow` reflects the effective state of block `qry_blk` in the same cycle.
- R2: After `por_n` or `rp_n` is pulled low, every block reads as not allowed, whatever its stored bit holds, until a protect-set sequence completes.
- R3: Protect-set is command 57h followed by D0h at an address whose bits 9:8 are 0 and bits 7:0 are FFh (other bits don't care). From the next cycle, the effective lock of each block equals its stored bit, and the master override is off.
- R4: Protect-reset is command 47h followed by D0h at the same address pattern as R3. From the next cycle, every block is allowed.
- R5: Lock-block is command 77h followed by D0h at a block address. It sets that block's stored bit only while protect-reset is in force. Otherwise it sets both error flags and changes nothing. The new lock takes effect only after a later protect-set.
- R6: Block erase is command 20h followed by D0h at a block address. If that block is allowed, `arr_er_go` pulses one cycle after the confirm cycle, `erase_sel` is one-hot on that block, and the block's stored bit is cleared.
- R7: Erase-all is command A7h followed by D0h. It is always accepted. `erase_sel` is the complement of the stored lock bits, even right after reset. Afterwards the effective lock equals the stored bits.
- R8: A confirm cycle whose data is not D0h, or a protect confirm with the wrong address pattern, sets both error flags and triggers no action.
- R9: A word write is command 40h or 10h followed by a data cycle. If the target block is allowed, `arr_wr_go` pulses with the captured address and data. If the block is locked, there is no pulse and `err_write` is set.
- R10: A block erase aimed at a locked block gives no `arr_er_go` pulse and sets `err_erase` only.
- R11: Command 50h clears both error flags.
- R12: Stored lock bits survive an `rp_n` reset and are cleared only by `por_n`.
- R13: An unrecognised first command byte leaves the sequencer idle: it causes no pulse, no flag and no change in protection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears everything, including the stored lock bits |
| rp_n | input | 1 | Reset/power-down, active low; clears effective protection, master latch, sequencer and flags |
| wr_en | input | 1 | Command bus write strobe, sampled on the rising clock edge |
| wr_addr | input | 19 | Command bus address |
| wr_data | input | 8 | Command bus data |
| qry_blk | input | 5 | Block index to query |
| qry_allow | output | 1 | 1 when block `qry_blk` may be written or erased |
| arr_wr_go | output | 1 | Single-cycle accepted-write pulse to the array |
| arr_er_go | output | 1 | Single-cycle accepted-erase pulse to the array |
| arr_addr | output | 19 | Address captured with the accepted request |
| arr_data | output | 8 | Data captured with the accepted request |
| erase_sel | output | 32 | Blocks to erase, valid with `arr_er_go`, zero otherwise |
| err_write | output | 1 | Sticky data-write error flag |
| err_erase | output | 1 | Sticky erase error flag |

## Verification
The bench builds the block with its default parameters: 32 blocks and a 14-bit offset. Both ends of the block index, block 0 and block 31, can then be reached through real address bits 18:14, and the 32-bit erase-select vector can be compared whole. The directed tests cover these sequences in turn:
- locking blocks under protect-reset;
- activating the locks with protect-set;
- an `rp_n` reset that hides the stored bits again, with erase-all run while they are still hidden;
- a final `por_n` that wipes them.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;

  localparam int CMD_W = 8;

  localparam logic [CMD_W-1:0] OP_WRITE_A = 8'h40;
  localparam logic [CMD_W-1:0] OP_WRITE_B = 8'h10;
  localparam logic [CMD_W-1:0] OP_ERASE   = 8'h20;
  localparam logic [CMD_W-1:0] OP_PSET    = 8'h57;
  localparam logic [CMD_W-1:0] OP_PRST    = 8'h47;
  localparam logic [CMD_W-1:0] OP_LOCK    = 8'h77;
  localparam logic [CMD_W-1:0] OP_EALL    = 8'hA7;
  localparam logic [CMD_W-1:0] OP_CLEAR   = 8'h50;
  localparam logic [CMD_W-1:0] OP_CONFIRM = 8'hD0;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WRITE,
    SQ_ERASE,
    SQ_PSET,
    SQ_PRST,
    SQ_LOCK,
    SQ_EALL
  } seq_st_e;

  typedef struct packed {
    logic wr;
    logic er;
    logic pset;
    logic prst;
    logic lock;
    logic eall;
    logic seq_err;
    logic clr;
  } seq_act_t;

endpackage

// File: rtl/blk_lock_seq.sv
module blk_lock_seq
  import blk_lock_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [9:0]       cfm_addr,
  input  logic [CMD_W-1:0] wr_data,
  output seq_act_t         act
);

  seq_st_e state_q;
  seq_st_e state_d;
  logic    is_confirm;
  logic    prot_ok;

  assign is_confirm = (wr_data == OP_CONFIRM);
  assign prot_ok    = is_confirm && (cfm_addr[9:8] == 2'b00) && (cfm_addr[7:0] == 8'hFF);

  always_comb begin
    state_d = state_q;
    act     = '0;
    if (wr_en) begin
      unique case (state_q)
        SQ_IDLE: begin
          unique case (wr_data)
            OP_WRITE_A, OP_WRITE_B: state_d = SQ_WRITE;
            OP_ERASE:               state_d = SQ_ERASE;
            OP_PSET:                state_d = SQ_PSET;
            OP_PRST:                state_d = SQ_PRST;
            OP_LOCK:                state_d = SQ_LOCK;
            OP_EALL:                state_d = SQ_EALL;
            OP_CLEAR:               act.clr = 1'b1;
            default:                state_d = SQ_IDLE;
          endcase
        end
        SQ_WRITE: begin
          state_d = SQ_IDLE;
          act.wr  = 1'b1;
        end
        SQ_ERASE: begin
          state_d     = SQ_IDLE;
          act.er      = is_confirm;
          act.seq_err = !is_confirm;
        end
        SQ_PSET: begin
          state_d     = SQ_IDLE;
          act.pset    = prot_ok;
          act.seq_err = !prot_ok;
        end
        SQ_PRST: begin
          state_d     = SQ_IDLE;
          act.prst    = prot_ok;
          act.seq_err = !prot_ok;
        end
        SQ_LOCK: begin
          state_d     = SQ_IDLE;
          act.lock    = is_confirm;
          act.seq_err = !is_confirm;
        end
        SQ_EALL: begin
          state_d     = SQ_IDLE;
          act.eall    = is_confirm;
          act.seq_err = !is_confirm;
        end
        default: state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  AST_SEQ_BACK_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && state_q != SQ_IDLE) |=> (state_q == SQ_IDLE)); // R8

  AST_SEQ_IDLE_JUNK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_IDLE) |-> !(act.wr || act.er || act.pset || act.prst || act.lock || act.eall || act.seq_err)); // R13

endmodule

// File: rtl/blk_lock_store.sv
module blk_lock_store #(
  parameter int NUM_BLK = 32,
  localparam int BLK_W  = $clog2(NUM_BLK)
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               set_en,
  input  logic [BLK_W-1:0]   set_idx,
  input  logic [NUM_BLK-1:0] clr_vec,
  output logic [NUM_BLK-1:0] lock_vec
);

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_bit
    logic bit_set;
    logic bit_clr;
    logic bit_q;

    assign bit_set = set_en && (set_idx == BLK_W'(b));
    assign bit_clr = clr_vec[b];

    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
        bit_q <= 1'b0;
      end else if (bit_set || bit_clr) begin
        bit_q <= bit_set;
      end
    end

    assign lock_vec[b] = bit_q;
  end

  AST_SET_CLR_APART: assert property (@(posedge clk) disable iff (!por_n)
    !(set_en && (clr_vec != '0))); // R5

endmodule

// File: rtl/blk_lock_gate.sv
module blk_lock_gate #(
  parameter int NUM_BLK = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               act_pset,
  input  logic               act_prst,
  input  logic               act_eall,
  input  logic [NUM_BLK-1:0] lock_vec,
  output logic [NUM_BLK-1:0] eff_lock,
  output logic               unprot
);

  logic valid_q;
  logic valid_d;
  logic unprot_q;
  logic unprot_d;

  always_comb begin
    valid_d  = valid_q;
    unprot_d = unprot_q;
    if (act_pset) begin
      valid_d  = 1'b1;
      unprot_d = 1'b0;
    end
    if (act_prst) begin
      unprot_d = 1'b1;
    end
    if (act_eall) begin
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      unprot_q <= 1'b0;
    end else begin
      valid_q  <= valid_d;
      unprot_q <= unprot_d;
    end
  end

  always_comb begin
    if (unprot_q) begin
      eff_lock = '0;
    end else if (valid_q) begin
      eff_lock = lock_vec;
    end else begin
      eff_lock = '1;
    end
  end

  assign unprot = unprot_q;

  AST_PSET_TRACKS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(act_pset) |-> (!unprot_q && (eff_lock == lock_vec))); // R3

  AST_OPEN_ONLY_BY_PRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unprot_q) |-> $past(act_prst)); // R4

endmodule

// File: rtl/blk_lock_mgr.sv
module blk_lock_mgr
  import blk_lock_pkg::*;
#(
  parameter int NUM_BLK  = 32,
  parameter int BLK_AW   = 14,
  localparam int BLK_W   = $clog2(NUM_BLK),
  localparam int ADDR_W  = BLK_AW + BLK_W
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               rp_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [CMD_W-1:0]   wr_data,
  input  logic [BLK_W-1:0]   qry_blk,
  output logic               qry_allow,
  output logic               arr_wr_go,
  output logic               arr_er_go,
  output logic [ADDR_W-1:0]  arr_addr,
  output logic [CMD_W-1:0]   arr_data,
  output logic [NUM_BLK-1:0] erase_sel,
  output logic               err_write,
  output logic               err_erase
);

  logic               rst_n;
  seq_act_t           act;
  logic [NUM_BLK-1:0] lock_vec;
  logic [NUM_BLK-1:0] eff_lock;
  logic               unprot;
  logic [BLK_W-1:0]   tgt_blk;
  logic [NUM_BLK-1:0] tgt_onehot;
  logic               tgt_locked;
  logic               wr_ok;
  logic               er_ok;
  logic               lock_ok;
  logic [NUM_BLK-1:0] clr_vec;

  logic               wr_go_q,  wr_go_d;
  logic               er_go_q,  er_go_d;
  logic [ADDR_W-1:0]  addr_q,   addr_d;
  logic [CMD_W-1:0]   data_q,   data_d;
  logic [NUM_BLK-1:0] sel_q,    sel_d;
  logic               err_w_q,  err_w_d;
  logic               err_e_q,  err_e_d;
  logic               cap_en;

  assign rst_n = por_n & rp_n;

  blk_lock_seq i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .cfm_addr (wr_addr[9:0]),
    .wr_data  (wr_data),
    .act      (act)
  );

  blk_lock_store #(.NUM_BLK(NUM_BLK)) i_store (
    .clk      (clk),
    .por_n    (por_n),
    .set_en   (lock_ok),
    .set_idx  (tgt_blk),
    .clr_vec  (clr_vec),
    .lock_vec (lock_vec)
  );

  blk_lock_gate #(.NUM_BLK(NUM_BLK)) i_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_pset (act.pset),
    .act_prst (act.prst),
    .act_eall (act.eall),
    .lock_vec (lock_vec),
    .eff_lock (eff_lock),
    .unprot   (unprot)
  );

  assign tgt_blk    = wr_addr[ADDR_W-1 -: BLK_W];
  assign tgt_onehot = {{(NUM_BLK-1){1'b0}}, 1'b1} << tgt_blk;
  assign tgt_locked = eff_lock[tgt_blk];
  assign wr_ok      = act.wr && !tgt_locked;
  assign er_ok      = act.er && !tgt_locked;
  assign lock_ok    = act.lock && unprot;
  assign clr_vec    = er_ok ? tgt_onehot : '0;
  assign qry_allow  = !eff_lock[qry_blk];

  always_comb begin
    wr_go_d = wr_ok;
    er_go_d = er_ok || act.eall;
    cap_en  = wr_ok || er_ok || act.eall;
    addr_d  = addr_q;
    data_d  = data_q;
    if (cap_en) begin
      addr_d = wr_addr;
      data_d = wr_data;
    end
    if (er_ok) begin
      sel_d = tgt_onehot;
    end else if (act.eall) begin
      sel_d = ~lock_vec;
    end else begin
      sel_d = '0;
    end
    err_w_d = err_w_q;
    err_e_d = err_e_q;
    if (act.clr) begin
      err_w_d = 1'b0;
      err_e_d = 1'b0;
    end
    if (act.seq_err || (act.lock && !unprot)) begin
      err_w_d = 1'b1;
      err_e_d = 1'b1;
    end
    if (act.wr && tgt_locked) begin
      err_w_d = 1'b1;
    end
    if (act.er && tgt_locked) begin
      err_e_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_go_q <= 1'b0;
      er_go_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      sel_q   <= '0;
      err_w_q <= 1'b0;
      err_e_q <= 1'b0;
    end else begin
      wr_go_q <= wr_go_d;
      er_go_q <= er_go_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      sel_q   <= sel_d;
      err_w_q <= err_w_d;
      err_e_q <= err_e_d;
    end
  end

  assign arr_wr_go = wr_go_q;
  assign arr_er_go = er_go_q;
  assign arr_addr  = addr_q;
  assign arr_data  = data_q;
  assign erase_sel = sel_q;
  assign err_write = err_w_q;
  assign err_erase = err_e_q;

  AST_LOCK_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((lock_vec & ~$past(lock_vec)) != '0) |-> $past(unprot)); // R5

  AST_SEQ_ERR_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(act.seq_err) |-> (err_w_q && err_e_q)); // R8

  AST_ERASED_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    er_go_q |-> ((sel_q & lock_vec) == '0)); // R6

  AST_SEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !er_go_q |-> (sel_q == '0)); // R6

  AST_SINGLE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(act.er) && er_go_q |-> $onehot(sel_q)); // R6

  AST_REFUSED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_w_q) |-> !wr_go_q); // R9

endmodule

// File: tb/test_blk_lock_mgr.sv
`timescale 1ns/1ps
module test_blk_lock_mgr;

  logic        clk = 1'b0;
  logic        por_n;
  logic        rp_n;
  logic        wr_en;
  logic [18:0] wr_addr;
  logic [7:0]  wr_data;
  logic [4:0]  qry_blk;
  logic        qry_allow;
  logic        arr_wr_go;
  logic        arr_er_go;
  logic [18:0] arr_addr;
  logic [7:0]  arr_data;
  logic [31:0] erase_sel;
  logic        err_write;
  logic        err_erase;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  blk_lock_mgr i_blk_lock_mgr (
    .clk       (clk),
    .por_n     (por_n),
    .rp_n      (rp_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .qry_blk   (qry_blk),
    .qry_allow (qry_allow),
    .arr_wr_go (arr_wr_go),
    .arr_er_go (arr_er_go),
    .arr_addr  (arr_addr),
    .arr_data  (arr_data),
    .erase_sel (erase_sel),
    .err_write (err_write),
    .err_erase (err_erase)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  function automatic logic [18:0] baddr(input int blk, input int off);
    return {blk[4:0], off[13:0]};
  endfunction

  task automatic bus(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic qchk(input int blk, input logic exp, input string req);
    qry_blk = blk[4:0];
    #1;
    check(req, {63'd0, qry_allow}, {63'd0, exp});
  endtask

  task automatic flags(input logic ew, input logic ee, input string req);
    check(req, {62'd0, err_write, err_erase}, {62'd0, ew, ee});
  endtask

  task automatic do_por();
    @(negedge clk);
    por_n = 1'b0;
    rp_n  = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    rp_n  = 1'b1;
  endtask

  task automatic do_rp();
    @(negedge clk);
    rp_n = 1'b0;
    repeat (2) @(negedge clk);
    rp_n = 1'b1;
  endtask

  task automatic pset(input logic [18:0] a);
    bus(19'h0, 8'h57);
    bus(a, 8'hD0);
  endtask

  task automatic prst();
    bus(19'h0, 8'h47);
    bus(19'h000FF, 8'hD0);
  endtask

  task automatic clr();
    bus(19'h0, 8'h50);
  endtask

  task automatic t_reset();
    do_por();
    qchk(0, 1'b0, "R2 block0 locked after power-on");
    qchk(31, 1'b0, "R2 block31 locked after power-on");
    flags(1'b0, 1'b0, "R2 flags clear after reset");
    check("R2 no pulses after reset", {62'd0, arr_wr_go, arr_er_go}, 64'd0);
  endtask

  task automatic t_pset();
    bus(baddr(3, 16), 8'h40);
    bus(baddr(3, 16), 8'h11);
    check("R9 write refused before protect-set", {63'd0, arr_wr_go}, 64'd0);
    flags(1'b1, 1'b0, "R9 write error before protect-set");
    clr();
    flags(1'b0, 1'b0, "R11 clear status");
    pset(19'h7C0FF);
    qchk(0, 1'b1, "R3 block0 open after protect-set");
    qchk(31, 1'b1, "R3 block31 open after protect-set");
  endtask

  task automatic t_write();
    bus(19'h0, 8'h40);
    bus(baddr(3, 14'h123), 8'h5A);
    check("R9 write pulse", {63'd0, arr_wr_go}, 64'd1);
    check("R9 write address", {45'd0, arr_addr}, {45'd0, baddr(3, 14'h123)});
    check("R9 write data", {56'd0, arr_data}, 64'h5A);
    bus(19'h0, 8'h10);
    bus(baddr(0, 0), 8'hA5);
    check("R9 alternate write pulse", {63'd0, arr_wr_go}, 64'd1);
    check("R9 alternate write data", {56'd0, arr_data}, 64'hA5);
  endtask

  task automatic t_lock();
    bus(19'h0, 8'h77);
    bus(baddr(5, 0), 8'hD0);
    flags(1'b1, 1'b1, "R5 lock refused without protect-reset");
    qchk(5, 1'b1, "R5 refused lock has no effect");
    clr();
    prst();
    qchk(9, 1'b1, "R4 all open under protect-reset");
    bus(19'h0, 8'h77);
    bus(baddr(5, 7), 8'hD0);
    bus(19'h0, 8'h77);
    bus(baddr(31, 0), 8'hD0);
    flags(1'b0, 1'b0, "R5 lock accepted under protect-reset");
    qchk(5, 1'b1, "R5 new lock not yet in effect");
    pset(19'h000FF);
    qchk(5, 1'b0, "R5 lock in effect after protect-set");
    qchk(31, 1'b0, "R1 block31 locked");
    qchk(4, 1'b1, "R1 neighbour block4 open");
  endtask

  task automatic t_locked_ops();
    bus(19'h0, 8'h40);
    bus(baddr(5, 1), 8'h33);
    check("R9 locked write no pulse", {63'd0, arr_wr_go}, 64'd0);
    flags(1'b1, 1'b0, "R9 locked write flags");
    clr();
    bus(19'h0, 8'h20);
    bus(baddr(5, 0), 8'hD0);
    check("R10 locked erase no pulse", {63'd0, arr_er_go}, 64'd0);
    flags(1'b0, 1'b1, "R10 locked erase flags");
    clr();
  endtask

  task automatic t_erase();
    bus(19'h0, 8'h20);
    bus(baddr(4, 0), 8'hD0);
    check("R6 erase pulse", {63'd0, arr_er_go}, 64'd1);
    check("R6 erase select", {32'd0, erase_sel}, 64'h10);
    @(negedge clk);
    check("R6 select drops after pulse", {32'd0, erase_sel}, 64'd0);
  endtask

  task automatic t_seq_err();
    bus(19'h0, 8'h20);
    bus(baddr(4, 0), 8'h55);
    check("R8 bad confirm no pulse", {63'd0, arr_er_go}, 64'd0);
    flags(1'b1, 1'b1, "R8 bad confirm flags");
    clr();
    prst();
    pset(19'h001FF);
    flags(1'b1, 1'b1, "R8 wrong protect address flags");
    qchk(5, 1'b1, "R8 wrong protect address ignored");
    clr();
    pset(19'h000FF);
    qchk(5, 1'b0, "R3 protect-set restores lock");
  endtask

  task automatic t_ignore();
    bus(19'h0, 8'h12);
    bus(baddr(4, 0), 8'hD0);
    check("R13 unknown command no pulse", {62'd0, arr_wr_go, arr_er_go}, 64'd0);
    flags(1'b0, 1'b0, "R13 unknown command no flag");
    qchk(5, 1'b0, "R13 unknown command keeps lock");
    qchk(4, 1'b1, "R13 unknown command keeps open");
  endtask

  task automatic t_rp_eall();
    do_rp();
    qchk(4, 1'b0, "R2 open block locked after rp reset");
    bus(19'h0, 8'hA7);
    bus(19'h0, 8'hD0);
    check("R7 erase-all pulse", {63'd0, arr_er_go}, 64'd1);
    check("R7 erase-all select", {32'd0, erase_sel}, 64'h7FFF_FFDF);
    qchk(4, 1'b1, "R7 effective follows store after erase-all");
    qchk(5, 1'b0, "R12 lock survives rp reset");
  endtask

  task automatic t_erase_lock_clear();
    prst();
    bus(19'h0, 8'h20);
    bus(baddr(5, 0), 8'hD0);
    check("R6 erase under protect-reset select", {32'd0, erase_sel}, 64'h20);
    pset(19'h000FF);
    qchk(5, 1'b1, "R6 erase cleared lock bit");
    qchk(31, 1'b0, "R6 other lock kept");
  endtask

  task automatic t_por_wipe();
    do_por();
    pset(19'h000FF);
    qchk(31, 1'b1, "R12 power-on clears stored bits");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R0 actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    por_n   = 1'b0;
    rp_n    = 1'b0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    qry_blk = '0;
    t_reset();
    t_pset();
    t_write();
    t_lock();
    t_locked_ops();
    t_erase();
    t_seq_err();
    t_ignore();
    t_rp_eall();
    t_erase_lock_clear();
    t_por_wipe();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule